// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block gathers the event sources of a UART into a single active-high level interrupt and a four-bit identification value that software reads to learn which source to service first. Five sources are handled: receive line errors, received data available, receive character timeout, transmit holding register empty, and a change on the modem inputs. Each source is gated by its own enable bit. Only the most urgent enabled source that is pending appears in the identification value.

The block owns the clearing rules. Line errors and modem changes stay latched until their status registers are read. The received-data source follows the receive level input. The timeout source is built from a character-time counter. The transmit-empty source is acknowledged by an identification read while it is the reported source, or by loading new transmit data. A freeze input holds the interrupt line low. The receiver, the transmitter and the bus decoder sit outside the block. They deliver single-cycle strobes and levels to it.

Top module: `uart_irq_top`

## Requirements
- R1: After reset, irq is 0, intId is 4'b0001, every enable bit is 0, and nothing is pending.
- R2: intId bit 0 is 1 exactly when no enabled source is pending. The codes are: line error 4'b0110, received data 4'b0100, timeout 4'b1100, transmit empty 4'b0010, modem change 4'b0000.
- R3: When several enabled sources are pending, intId reports the highest one in this order: line error, received data, timeout, transmit empty, modem change. Received data outranks timeout.
- R4: An enWr pulse loads enData into the enable register, and the new value takes effect from the next cycle. The enable bits are: bit 0 received data, bit 1 transmit empty, bit 2 line error, bit 3 modem change, bit 4 timeout. A pending source whose bit is 0 is not reported and does not raise irq.
- R5: irq is 1 whenever freeze is 0 and at least one enabled source is pending.
- R6: While freeze is 1, irq is 0. intId is not affected by freeze.
- R7: A lineErrEvt pulse sets the line source from the next cycle on. An lsrRead pulse clears it. If both arrive in the same cycle, the source stays set.
- R8: A modemChgEvt pulse sets the modem source, and an msrRead pulse clears it. If both arrive in the same cycle, the source stays set.
- R9: The received-data source equals rxAvail delayed by one clock.
- R10: The timeout count goes to zero in any cycle where rxNonEmpty is 0 or rxActivity is 1. Otherwise each charTick advances it, up to TMO_CHARS (default 4). The timeout source is pending while the count equals TMO_CHARS.
- R11: The transmit-empty source is set on a 0-to-1 change of thrEmpty. It is also set when an enWr turns enable bit 1 from 0 to 1 while thrEmpty is 1.
- R12: The transmit-empty source is cleared by txWrite, or by iirRead in a cycle where intId is 4'b0010. An iirRead while another code is shown leaves it pending. When a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Holds irq low while high |
| enWr | input | 1 | Load strobe for the enable register |
| enData | input | 5 | New enable bits |
| lineErrEvt | input | 1 | Receive line error detected (pulse) |
| lsrRead | input | 1 | Line status register read (pulse) |
| modemChgEvt | input | 1 | Modem input change detected (pulse) |
| msrRead | input | 1 | Modem status register read (pulse) |
| rxAvail | input | 1 | Receive data at or above trigger level |
| rxNonEmpty | input | 1 | Receive FIFO holds at least one character |
| rxActivity | input | 1 | Character received or FIFO read (pulse) |
| charTick | input | 1 | One pulse per character time |
| thrEmpty | input | 1 | Transmit holding register empty |
| txWrite | input | 1 | New transmit data written (pulse) |
| iirRead | input | 1 | Identification register read (pulse) |
| irq | output | 1 | Level interrupt, active high |
| intId | output | 4 | Identification value of the reported source |

## Verification
Directed cases first raise sources one by one, then stack them. This separates a wrong code from a wrong priority. Received data and timeout are pending together to settle the tie at the second level. Set and clear strobes are driven in the same cycle to show which one wins. An identification read is issued both while transmit-empty is reported and while a higher source hides it, which tells the conditional acknowledge apart from an unconditional one. Long random runs then mix enable writes, freeze, and sparse event and read strobes, and a bench model of the requirements predicts irq and intId in every cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC = 5;

  // enable register bit positions
  localparam int EN_RXDATA  = 0;
  localparam int EN_THRE    = 1;
  localparam int EN_LINE    = 2;
  localparam int EN_MODEM   = 3;
  localparam int EN_TIMEOUT = 4;

  // priority slots, 0 is most urgent
  localparam int SLOT_LINE    = 0;
  localparam int SLOT_RXDATA  = 1;
  localparam int SLOT_TIMEOUT = 2;
  localparam int SLOT_THRE    = 3;
  localparam int SLOT_MODEM   = 4;

  localparam logic [3:0] ID_LINE    = 4'b0110;
  localparam logic [3:0] ID_RXDATA  = 4'b0100;
  localparam logic [3:0] ID_TIMEOUT = 4'b1100;
  localparam logic [3:0] ID_THRE    = 4'b0010;
  localparam logic [3:0] ID_MODEM   = 4'b0000;
  localparam logic [3:0] ID_NONE    = 4'b0001;

  typedef struct packed {
    logic setLine;
    logic clrLine;
    logic setModem;
    logic clrModem;
    logic setThre;
    logic clrThre;
    logic tmoClear;
    logic tmoTick;
  } irqStrobes_t;

  function automatic logic [3:0] slotCode(input int slot);
    case (slot)
      SLOT_LINE:    return ID_LINE;
      SLOT_RXDATA:  return ID_RXDATA;
      SLOT_TIMEOUT: return ID_TIMEOUT;
      SLOT_THRE:    return ID_THRE;
      default:      return ID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enWr,
  input  logic        enThreNew,
  input  logic        enThreCur,
  input  logic        lineErrEvt,
  input  logic        lsrRead,
  input  logic        modemChgEvt,
  input  logic        msrRead,
  input  logic        rxNonEmpty,
  input  logic        rxActivity,
  input  logic        charTick,
  input  logic        thrEmpty,
  input  logic        txWrite,
  input  logic        iirRead,
  input  logic [3:0]  curId,
  output irqStrobes_t strobes
);

  logic prevThr;
  logic thrRise;
  logic enRise;

  always_ff @(posedge clk) begin
    if (!rstN) prevThr <= 1'b1;
    else       prevThr <= thrEmpty;
  end

  assign thrRise = thrEmpty & ~prevThr;
  assign enRise  = enWr & enThreNew & ~enThreCur & thrEmpty;

  always_comb begin
    strobes          = '0;
    strobes.setLine  = lineErrEvt;
    strobes.clrLine  = lsrRead;
    strobes.setModem = modemChgEvt;
    strobes.clrModem = msrRead;
    strobes.setThre  = thrRise | enRise;
    strobes.clrThre  = txWrite | (iirRead & (curId == ID_THRE));
    strobes.tmoClear = ~rxNonEmpty | rxActivity;
    strobes.tmoTick  = charTick;
  end

  AST_THRE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (iirRead && curId == ID_THRE && !thrRise && !enRise) |=> (curId != ID_THRE)); // R12

  AST_THRE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && !thrRise && !enRise) |=> (curId != ID_THRE)); // R12

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int TMO_CHARS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               freeze,
  input  logic               enWr,
  input  logic [NUM_SRC-1:0] enData,
  input  logic               rxAvail,
  input  irqStrobes_t        strobes,
  output logic               enThreCur,
  output logic [3:0]         curId,
  output logic               irq
);

  localparam int CW = $clog2(TMO_CHARS + 1);
  localparam logic [CW-1:0] TMO_MAX = CW'(TMO_CHARS);

  logic [NUM_SRC-1:0] enReg;
  logic               linePend;
  logic               modemPend;
  logic               threPend;
  logic               rxPend;
  logic [CW-1:0]      tmoCnt;
  logic               tmoPend;
  logic [NUM_SRC-1:0] slotReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= '0;
      linePend  <= 1'b0;
      modemPend <= 1'b0;
      threPend  <= 1'b0;
      rxPend    <= 1'b0;
      tmoCnt    <= '0;
    end else begin
      if (enWr) enReg <= enData;
      linePend  <= strobes.setLine  | (linePend  & ~strobes.clrLine);
      modemPend <= strobes.setModem | (modemPend & ~strobes.clrModem);
      threPend  <= strobes.setThre  | (threPend  & ~strobes.clrThre);
      rxPend    <= rxAvail;
      if (strobes.tmoClear)                       tmoCnt <= '0;
      else if (strobes.tmoTick && tmoCnt != TMO_MAX) tmoCnt <= tmoCnt + 1'b1;
    end
  end

  assign tmoPend   = (tmoCnt == TMO_MAX);
  assign enThreCur = enReg[EN_THRE];

  always_comb begin
    slotReq               = '0;
    slotReq[SLOT_LINE]    = linePend  & enReg[EN_LINE];
    slotReq[SLOT_RXDATA]  = rxPend    & enReg[EN_RXDATA];
    slotReq[SLOT_TIMEOUT] = tmoPend   & enReg[EN_TIMEOUT];
    slotReq[SLOT_THRE]    = threPend  & enReg[EN_THRE];
    slotReq[SLOT_MODEM]   = modemPend & enReg[EN_MODEM];
  end

  // lowest slot index wins: scan from the back so earlier slots override
  always_comb begin
    curId = ID_NONE;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (slotReq[s]) curId = slotCode(s);
    end
  end

  assign irq = (|slotReq) & ~freeze;

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (linePend && !strobes.clrLine) |=> linePend); // R7

  AST_MODEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modemPend && !strobes.clrModem) |=> modemPend); // R8

  AST_TMO_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tmoClear |=> !tmoPend); // R10

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    slotReq[SLOT_LINE] |-> (curId == ID_LINE)); // R3

  AST_NONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    curId[0] == !(|slotReq)); // R2

  AST_RX_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    rxAvail |=> rxPend); // R9

endmodule

// File: rtl/uart_irq_top.sv
module uart_irq_top
  import uart_irq_pkg::*;
#(
  parameter int TMO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       freeze,
  input  logic       enWr,
  input  logic [4:0] enData,
  input  logic       lineErrEvt,
  input  logic       lsrRead,
  input  logic       modemChgEvt,
  input  logic       msrRead,
  input  logic       rxAvail,
  input  logic       rxNonEmpty,
  input  logic       rxActivity,
  input  logic       charTick,
  input  logic       thrEmpty,
  input  logic       txWrite,
  input  logic       iirRead,
  output logic       irq,
  output logic [3:0] intId
);

  irqStrobes_t strobes;
  logic        enThreCur;
  logic [3:0]  curId;

  uart_irq_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enWr        (enWr),
    .enThreNew   (enData[EN_THRE]),
    .enThreCur   (enThreCur),
    .lineErrEvt  (lineErrEvt),
    .lsrRead     (lsrRead),
    .modemChgEvt (modemChgEvt),
    .msrRead     (msrRead),
    .rxNonEmpty  (rxNonEmpty),
    .rxActivity  (rxActivity),
    .charTick    (charTick),
    .thrEmpty    (thrEmpty),
    .txWrite     (txWrite),
    .iirRead     (iirRead),
    .curId       (curId),
    .strobes     (strobes)
  );

  uart_irq_datapath #(.TMO_CHARS(TMO_CHARS)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .freeze    (freeze),
    .enWr      (enWr),
    .enData    (enData),
    .rxAvail   (rxAvail),
    .strobes   (strobes),
    .enThreCur (enThreCur),
    .curId     (curId),
    .irq       (irq)
  );

  assign intId = curId;

  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    freeze |-> !irq); // R6

endmodule

// File: tb/test_uart_irq_top.sv
`timescale 1ns/1ps
module test_uart_irq_top;

  localparam real HALF = 2.5;
  localparam int  TMO  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic freeze = 1'b0, enWr = 1'b0;
  logic [4:0] enData = '0;
  logic lineErrEvt = 0, lsrRead = 0, modemChgEvt = 0, msrRead = 0;
  logic rxAvail = 0, rxNonEmpty = 0, rxActivity = 0, charTick = 0;
  logic thrEmpty = 1, txWrite = 0, iirRead = 0;
  logic irq;
  logic [3:0] intId;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // reference state
  logic [4:0] mEn;
  logic mLine, mModem, mThre, mRx, mPrevThr;
  int   mCnt;

  always #(HALF) clk = ~clk;

  uart_irq_top #(.TMO_CHARS(TMO)) i_uart_irq_top (
    .clk(clk), .rstN(rstN), .freeze(freeze), .enWr(enWr), .enData(enData),
    .lineErrEvt(lineErrEvt), .lsrRead(lsrRead), .modemChgEvt(modemChgEvt),
    .msrRead(msrRead), .rxAvail(rxAvail), .rxNonEmpty(rxNonEmpty),
    .rxActivity(rxActivity), .charTick(charTick), .thrEmpty(thrEmpty),
    .txWrite(txWrite), .iirRead(iirRead), .irq(irq), .intId(intId)
  );

  function automatic logic [3:0] expId();
    if (mLine && mEn[2])          return 4'b0110;
    if (mRx && mEn[0])            return 4'b0100;
    if (mCnt == TMO && mEn[4])    return 4'b1100;
    if (mThre && mEn[1])          return 4'b0010;
    if (mModem && mEn[3])         return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic logic expIrq();
    return (expId() != 4'b0001) && !freeze;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mEn = '0; mLine = 0; mModem = 0; mThre = 0; mRx = 0; mPrevThr = 1; mCnt = 0;
  endtask

  task automatic idle();
    enWr = 0; lineErrEvt = 0; lsrRead = 0; modemChgEvt = 0; msrRead = 0;
    rxActivity = 0; charTick = 0; txWrite = 0; iirRead = 0;
  endtask

  // advance one clock, update the model and compare
  task automatic step(input string tag);
    logic setT, clrT;
    logic [4:0] nEn;
    int nCnt;
    setT = (thrEmpty && !mPrevThr) || (enWr && enData[1] && !mEn[1] && thrEmpty);
    clrT = txWrite || (iirRead && expId() == 4'b0010);
    nEn  = enWr ? enData : mEn;
    if (!rxNonEmpty || rxActivity) nCnt = 0;
    else if (charTick && mCnt != TMO) nCnt = mCnt + 1;
    else nCnt = mCnt;
    @(posedge clk); #1;
    mThre    = setT | (mThre & !clrT);
    mLine    = lineErrEvt | (mLine & !lsrRead);
    mModem   = modemChgEvt | (mModem & !msrRead);
    mRx      = rxAvail;
    mPrevThr = thrEmpty;
    mEn      = nEn;
    mCnt     = nCnt;
    chk(intId == expId(), {tag, " intId R3"}, intId, expId());
    chk(irq == expIrq(), {tag, " irq R5"}, irq, expIrq());
  endtask

  task automatic chkId(input string req, input logic [3:0] exp);
    chk(intId == exp, req, intId, exp);
  endtask

  initial begin
    #(2 * HALF * 200000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    #1; rstN = 1;
    // R1: reset state
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chkId("R1 intId after reset", 4'b0001);

    // R4: disabled source not reported
    idle(); lineErrEvt = 1; step("R4");
    idle(); step("R4");
    chkId("R4 line pending but disabled", 4'b0001);
    chk(irq == 0, "R4 irq with all disabled", irq, 0);

    // R11 / R3: enable all while thrEmpty high; line outranks transmit empty
    idle(); enWr = 1; enData = 5'b11111; step("R11");
    chkId("R3 line over thre", 4'b0110);
    idle(); lsrRead = 1; step("R7");
    chkId("R11 thre set by enable rise", 4'b0010);
    // R12: identification read acknowledges thre
    idle(); iirRead = 1; step("R12");
    chkId("R12 thre cleared by id read", 4'b0001);

    // R8 / R6
    idle(); modemChgEvt = 1; step("R8");
    chkId("R8 modem code", 4'b0000);
    chk(irq == 1, "R5 irq on modem", irq, 1);
    freeze = 1; #1;
    chk(irq == 0, "R6 irq frozen", irq, 0);
    chkId("R6 id unaffected by freeze", 4'b0000);
    freeze = 0;
    idle(); msrRead = 1; modemChgEvt = 1; step("R8");
    chkId("R8 set wins over read", 4'b0000);
    idle(); msrRead = 1; step("R8");
    chkId("R8 cleared by status read", 4'b0001);

    // R10: timeout after exactly TMO ticks
    idle(); rxNonEmpty = 1;
    for (int i = 0; i < TMO - 1; i++) begin charTick = 1; step("R10"); end
    chkId("R10 no timeout after 3 ticks", 4'b0001);
    charTick = 1; step("R10");
    chkId("R10 timeout after 4 ticks", 4'b1100);
    // R9 / R3: received data outranks timeout
    idle(); rxAvail = 1; step("R9");
    chkId("R9 rx data wins at level two", 4'b0100);
    rxAvail = 0; step("R9");
    chkId("R9 rx level dropped", 4'b1100);
    rxActivity = 1; step("R10");
    chkId("R10 activity clears timeout", 4'b0001);
    idle(); rxNonEmpty = 0; step("R10");

    // R12: id read while line is reported leaves thre
    thrEmpty = 0; step("R11");
    thrEmpty = 1; lineErrEvt = 1; step("R11");
    chkId("R3 line shown over new thre", 4'b0110);
    idle(); iirRead = 1; step("R12");
    chkId("R12 line still shown", 4'b0110);
    idle(); lsrRead = 1; lineErrEvt = 1; step("R7");
    chkId("R7 set wins over read", 4'b0110);
    idle(); lsrRead = 1; step("R7");
    chkId("R12 thre survived hidden read", 4'b0010);
    idle(); txWrite = 1; step("R12");
    chkId("R12 thre cleared by tx write", 4'b0001);

    // R2 codes under random traffic
    for (int n = 0; n < 5000; n++) begin
      idle();
      enWr        = ($urandom_range(0, 99) < 4);
      enData      = 5'($urandom());
      freeze      = ($urandom_range(0, 99) < 10);
      lineErrEvt  = ($urandom_range(0, 99) < 3);
      lsrRead     = ($urandom_range(0, 99) < 6);
      modemChgEvt = ($urandom_range(0, 99) < 3);
      msrRead     = ($urandom_range(0, 99) < 6);
      if ($urandom_range(0, 99) < 5) rxAvail = ~rxAvail;
      if ($urandom_range(0, 99) < 4) rxNonEmpty = ~rxNonEmpty;
      rxActivity  = ($urandom_range(0, 99) < 3);
      charTick    = ($urandom_range(0, 99) < 25);
      if ($urandom_range(0, 99) < 5) thrEmpty = ~thrEmpty;
      txWrite     = ($urandom_range(0, 99) < 3);
      iirRead     = ($urandom_range(0, 99) < 8);
      step("R2 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule